// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a register-mapped watchdog. Software programs a timeout constant, enables the dog and must then keep reloading a down-counter by writing a two-value key to a feed register. Each watchdog tick strobe goes through a fixed divide-by-four prescaler before it decrements the counter. If the counter runs out, the block sets a timeout flag. If reset generation is selected, it also raises a system reset request for a fixed number of clock cycles.

Only power-on reset clears the block's own state. The timeout flag therefore survives the system reset that the watchdog requests. After restart, software reads the flag to learn why the system went down. All writes are synchronous. A read returns its data one clock after it is requested.

Register addresses (reg_addr): 0 = mode, 1 = timeout constant, 2 = feed (write only, reads 0), 3 = current count (read only). Mode bits: bit 0 enable, bit 1 reset-on-timeout, bit 2 timeout flag.

Top module: `fsw_watchdog`

## Requirements
- R1: After power-on reset the mode register reads 0, the timeout constant and the current count both read 0xFFFF, and sys_rst_req is low.
- R2: Once the enable bit (mode bit 0) is set, a mode write with bit 0 = 0 leaves it set. Only power-on reset clears it.
- R3: While enabled, a feed-register write of 0x00AA followed by a feed-register write of 0x0055 loads the count with the timeout constant and starts the counter.
- R4: The feed sequence is aborted, with no reload, if the write after 0x00AA is not 0x0055 or if a write to another register comes between the two feed writes.
- R5: After enabling, the counter does not move until the first valid feed.
- R6: The counter drops by one on every fourth wd_tick strobe after a reload, and by nothing in between.
- R7: When a decrement brings the count to 0 (or a decrement is due at a count of 0 or 1) with mode bit 1 set, the flag (mode bit 2) is set and sys_rst_req is high for exactly RST_CYC (default 8) cycles.
- R8: A timeout with mode bit 1 clear sets the flag but leaves sys_rst_req low.
- R9: The flag stays set through the reset request. It clears only when a mode write has bit 2 = 0. A mode write with bit 2 = 1 does not set it.
- R10: A valid feed sequence while the enable bit is clear does not change the count.
- R11: After a timeout the count stays at 0 through further ticks until the next valid feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW (16) | Write data |
| reg_rdata | output | DW (16) | Read data, valid the cycle after reg_rd |
| wd_tick | input | 1 | Watchdog tick strobe, one clock wide |
| sys_rst_req | output | 1 | System reset request |

## Verification
Reads are registered, so each read result is due one clock after reg_rd is sampled high. The bench pushes the expected value into a queue when it issues the read. A monitor snapshots reg_rd at the edge and compares a quarter period later.

A reload is visible at the first read after the second feed write. A decrement is visible at the edge of the fourth tick. The flag and sys_rst_req change at the same edge as the final decrement. Every value is checked only after the stimulus task has returned, at a falling edge. The reset pulse length is measured by sampling sys_rst_req once per cycle from that falling edge onward.

// File: rtl/fsw_wdt_pkg.sv
package fsw_wdt_pkg;
  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_TOUT = 2'd1,
    ADR_FEED = 2'd2,
    ADR_CNT  = 2'd3
  } wdt_addr_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_HALF = 1'b1
  } feed_st_e;

  localparam int MODE_EN   = 0;
  localparam int MODE_RST  = 1;
  localparam int MODE_FLAG = 2;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  // true when a full write word equals an 8-bit key zero-extended
  function automatic logic key_match(input logic [31:0] word, input logic [7:0] key);
    return word == {24'd0, key};
  endfunction
endpackage

// File: rtl/fsw_feed_seq.sv
module fsw_feed_seq
  import fsw_wdt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          feed_ok
);
  feed_st_e st_q, st_d;
  logic [31:0] wd32;
  logic        feed_wr;

  assign wd32    = 32'(wr_data);
  assign feed_wr = wr_en && (wr_addr == ADR_FEED);

  always_comb begin
    st_d    = st_q;
    feed_ok = 1'b0;
    if (wr_en) begin
      if (feed_wr) begin
        if (st_q == FS_HALF && key_match(wd32, FEED_KEY2)) begin
          feed_ok = 1'b1;
          st_d    = FS_IDLE;
        end else if (key_match(wd32, FEED_KEY1)) begin
          st_d = FS_HALF;
        end else begin
          st_d = FS_IDLE;
        end
      end else begin
        st_d = FS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  // R4: a write to another register breaks any half-done sequence
  a_r4_abort_other: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !feed_wr) |=> !feed_ok);
endmodule

// File: rtl/fsw_tick_presc.sv
module fsw_tick_presc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic step
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  assign step = run && tick && (q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (run && tick) q <= wrap_inc(q);
  end

  // R6: decrement strobes can never come on consecutive cycles
  a_r6_step_spacing: assert property (@(posedge clk) disable iff (!por_n)
    step |=> !step);
endmodule

// File: rtl/fsw_down_cnt.sv
module fsw_down_cnt #(
  parameter int          DW      = 16,
  parameter logic [DW-1:0] RST_VAL = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  output logic [DW-1:0] cnt,
  output logic          armed,
  output logic          tmo_evt
);
  function automatic logic [DW-1:0] dec_sat(input logic [DW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic last_step(input logic [DW-1:0] v);
    return v <= DW'(1);
  endfunction

  assign tmo_evt = step && armed && last_step(cnt);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= RST_VAL;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else if (step && armed) begin
      cnt <= dec_sat(cnt);
      if (last_step(cnt)) armed <= 1'b0;
    end
  end

  // R3: a reload lands the constant and arms the counter
  a_r3_reload: assert property (@(posedge clk) disable iff (!por_n)
    load |=> (cnt == $past(load_val)) && armed);
  // R11: an idle (not armed) counter holds its value until a reload
  a_r11_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!load && !armed) |=> $stable(cnt));
endmodule

// File: rtl/fsw_watchdog.sv
module fsw_watchdog
  import fsw_wdt_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            PRESC_DIV = 4,
  parameter int            RST_CYC   = 8,
  parameter logic [DW-1:0] TOUT_RST  = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          wd_tick,
  output logic          sys_rst_req
);
  localparam int RCW = $clog2(RST_CYC + 1);

  logic          en_q, rsten_q, flag_q;
  logic [DW-1:0] tout_q;
  logic [RCW-1:0] rst_cnt;
  logic [DW-1:0] rdata_q;

  // named internal events
  logic          feed_ok, reload, step, armed, tmo_evt;
  logic          mode_wr, tout_wr;
  logic [DW-1:0] cnt;

  assign mode_wr = reg_wr && (reg_addr == ADR_MODE);
  assign tout_wr = reg_wr && (reg_addr == ADR_TOUT);
  assign reload  = feed_ok && en_q;

  fsw_feed_seq #(.DW(DW)) u_feed (
    .clk(clk), .por_n(por_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .feed_ok(feed_ok)
  );

  fsw_tick_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .por_n(por_n), .run(armed), .clr(reload),
    .tick(wd_tick), .step(step)
  );

  fsw_down_cnt #(.DW(DW), .RST_VAL(TOUT_RST)) u_cnt (
    .clk(clk), .por_n(por_n), .load(reload), .load_val(tout_q),
    .step(step), .cnt(cnt), .armed(armed), .tmo_evt(tmo_evt)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      flag_q  <= 1'b0;
      tout_q  <= TOUT_RST;
    end else begin
      if (mode_wr) begin
        en_q    <= en_q | reg_wdata[MODE_EN];
        rsten_q <= reg_wdata[MODE_RST];
      end
      if (tout_wr) tout_q <= reg_wdata;
      if (tmo_evt)                               flag_q <= 1'b1;
      else if (mode_wr && !reg_wdata[MODE_FLAG]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 rst_cnt <= '0;
    else if (tmo_evt && rsten_q) rst_cnt <= RCW'(RST_CYC);
    else if (rst_cnt != '0)      rst_cnt <= rst_cnt - 1'b1;
  end

  assign sys_rst_req = (rst_cnt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rdata_q <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADR_MODE: rdata_q <= DW'({flag_q, rsten_q, en_q});
        ADR_TOUT: rdata_q <= tout_q;
        ADR_CNT:  rdata_q <= cnt;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  // R2: enable never drops once set
  a_r2_en_sticky: assert property (@(posedge clk) disable iff (!por_n)
    en_q |=> en_q);
  // R7: a timeout with reset selected raises the request next cycle
  a_r7_fire: assert property (@(posedge clk) disable iff (!por_n)
    (tmo_evt && rsten_q) |=> sys_rst_req);
  // R7: the request never starts without the flag being set
  a_r7_rise_flag: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_req) |-> flag_q);
  // R8: a timeout without reset selected keeps the request low
  a_r8_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (tmo_evt && !rsten_q && !sys_rst_req) |=> !sys_rst_req);
  // R9: only a software clear drops the flag
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !(mode_wr && !reg_wdata[MODE_FLAG])) |=> flag_q);
endmodule

// File: tb/fsw_watchdog_tb_top.sv
module fsw_watchdog_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int RST_CYC = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, wd_tick = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic sys_rst_req;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  fsw_watchdog #(.DW(DW), .PRESC_DIV(4), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wd_tick(wd_tick), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: issue a read and queue what it must return
  task automatic rd(input logic [1:0] a, input logic [DW-1:0] e, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wd_tick = 1'b1;
      @(negedge clk); wd_tick = 1'b0;
    end
  endtask

  task automatic feed();
    wr(2'd2, 16'h00AA);
    wr(2'd2, 16'h0055);
  endtask

  task automatic pulse_len(input string req, input int exp);
    int hi = 0;
    for (int i = 0; i < 3 * RST_CYC; i++) begin
      if (sys_rst_req) hi++;
      @(negedge clk);
    end
    check(req, hi, exp);
  endtask

  // monitor: result is due one edge after the read strobe
  always @(posedge clk) begin
    logic hit;
    hit = reg_rd;
    #(CLK_P/4);
    if (hit) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), int'(reg_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    check("R1 rst_req", int'(sys_rst_req), 0);
    rd(2'd0, 16'h0000, "R1 mode");
    rd(2'd1, 16'hFFFF, "R1 timeout");
    rd(2'd3, 16'hFFFF, "R1 count");
    // R10 feed ignored while disabled
    wr(2'd1, 16'd10);
    feed();
    rd(2'd3, 16'hFFFF, "R10 count after disabled feed");
    // R5 enabled but not fed: counter idle
    wr(2'd0, 16'h0001);
    ticks(8);
    rd(2'd3, 16'hFFFF, "R5 count before first feed");
    // R2 enable sticky
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0001, "R2 enable sticky");
    // R3 reload and R6 prescaling
    feed();
    rd(2'd3, 16'd10, "R3 reload");
    ticks(4);
    rd(2'd3, 16'd9, "R6 after 4 ticks");
    ticks(3);
    rd(2'd3, 16'd9, "R6 after 7 ticks");
    ticks(1);
    rd(2'd3, 16'd8, "R6 after 8 ticks");
    // R4 aborted sequences
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h0012);
    rd(2'd3, 16'd8, "R4 wrong second key");
    wr(2'd2, 16'h00AA); wr(2'd1, 16'd10); wr(2'd2, 16'h0055);
    rd(2'd3, 16'd8, "R4 interleaved write");
    feed();
    rd(2'd3, 16'd10, "R3 reload after abort");
    // R8 timeout without reset
    wr(2'd1, 16'd2);
    feed();
    ticks(8);
    pulse_len("R8 no reset pulse", 0);
    rd(2'd0, 16'h0005, "R8 flag set");
    // R11 counter parked at zero
    ticks(8);
    rd(2'd3, 16'd0, "R11 count held");
    // R9 software clear, no software set
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0001, "R9 flag cleared");
    wr(2'd0, 16'h0005);
    rd(2'd0, 16'h0001, "R9 flag not settable");
    // R7 timeout with reset
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'd3);
    feed();
    ticks(11);
    check("R7 no pulse before final step", int'(sys_rst_req), 0);
    ticks(1);
    check("R7 pulse starts", int'(sys_rst_req), 1);
    pulse_len("R7 pulse length", RST_CYC);
    rd(2'd0, 16'h0007, "R9 flag survives reset request");
    wr(2'd0, 16'h0003);
    rd(2'd0, 16'h0003, "R9 flag cleared by write");
    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule